// File: doc/BRIEF.md
# Bit-Serial SIMD Array Behind a Memory Port

This block looks like a one-bit-wide memory to the host, but every column of that memory belongs to its own one-bit processing element. The elements sit on a two-dimensional torus of `ROWS` x `COLS` elements. Each element owns `2**BIT_AW` private bits, an accumulator, a carry flag and an enable (mask) flag. The host reaches all of this through a single port: one address, a write strobe and one data bit.

The top address bit picks what an access means. With that bit at 0, the access reads or writes a single stored bit. The element number and the bit number are taken from the lower address fields. With that bit at 1, a write carries an instruction instead of data, and the address field holds it. In that same clock, every element carries out the instruction on the same bit position of its own storage.

Arithmetic is bit-serial. A multi-bit add is a sequence of load, add and store steps run from the least significant bit upward. Data moves between elements one step north, south, east or west, and it wraps at the array edges. A per-element mask lets the host switch groups of elements off, so that they behave as if they had received a no-op.

Top module: `pim_array`

## Requirements
- R1: With address bit `AW` at 0, a write stores `memWdata` at element `memAddr[AW-1:BIT_AW]` (element index = row*COLS+col) and bit `memAddr[BIT_AW-1:0]`. A read returns that bit on `memRdata` in the cycle after the access. `memRdata` is 0 in every cycle that does not follow a host data read.
- R2: A write with address bit `AW` at 1 is an instruction. Its opcode is `memAddr[BIT_AW+3:BIT_AW]` and its bit operand is `memAddr[BIT_AW-1:0]`. Every enabled element executes it in the same clock. Opcode 1 copies the operand bit into the accumulator. Opcode 2 writes the accumulator into the operand bit. Opcodes 0 and 15 do nothing.
- R3: Opcodes 3, 4 and 5 replace the accumulator with its AND, OR and XOR with the operand bit. Opcode 6 inverts the accumulator.
- R4: Opcode 7 adds the operand bit, the accumulator and the carry flag. The sum bit goes to the accumulator and the carry-out goes to the carry flag. Opcode 14 clears the carry flag.
- R5: Opcodes 8, 9, 10 and 11 make each accumulator take the pre-instruction accumulator of a neighbour, wrapping at the edges. Opcode 8 takes it from the row below (data moves north). Opcode 9 takes it from the row above (south). Opcode 10 takes it from the column to the west (east). Opcode 11 takes it from the column to the east (west).
- R6: An element whose mask flag is 0 treats opcodes 1-11 and 14 as no-ops. Opcode 12 copies each element's accumulator into its mask flag. Opcode 13 sets every mask flag to 1. Both of these act in every element whatever its mask.
- R7: A masked element keeps its own accumulator during a shift, but its accumulator still serves as the source for the neighbour that reads it in that same shift.
- R8: A read with address bit `AW` at 1 executes nothing. It makes `memRdata` 0 in the next cycle and sets `errFlag`, which then stays 1 until reset.
- R9: After reset every accumulator and carry is 0, every mask is 1, every stored bit is 0 and `errFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memEn | input | 1 | Access strobe |
| memWr | input | 1 | 1 = write or instruction, 0 = read |
| memAddr | input | AW+1 | Mode bit on top, then element/opcode field, then bit field |
| memWdata | input | 1 | Bit to store on a host write |
| memRdata | output | 1 | Registered read data |
| errFlag | output | 1 | Sticky flag for a read made in instruction mode |

## Verification
The hard overlap is a shift in which some elements are masked. In the same clock, a masked element must hold its own accumulator while still supplying its old value to the neighbour that pulls from it. The bench provokes this by loading an accumulator pattern and then loading masks from another pattern, so that masked and unmasked elements sit next to each other on both torus edges. It then shifts in every direction and stores the result. A behavioural reference model that copies all accumulators before a shift judges the stored bits read back over the host port, and it does so on every clock.

// File: rtl/pim_pkg.sv
package pim_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_LOAD    = 4'd1,
    OP_STORE   = 4'd2,
    OP_AND     = 4'd3,
    OP_OR      = 4'd4,
    OP_XOR     = 4'd5,
    OP_NOT     = 4'd6,
    OP_ADD     = 4'd7,
    OP_SHN     = 4'd8,
    OP_SHS     = 4'd9,
    OP_SHE     = 4'd10,
    OP_SHW     = 4'd11,
    OP_MASKLD  = 4'd12,
    OP_MASKALL = 4'd13,
    OP_CLRC    = 4'd14,
    OP_IDLE    = 4'd15
  } opcode_e;

  typedef struct packed {
    logic    hostWr;
    logic    hostRd;
    logic    instGo;
    opcode_e op;
  } strobe_t;
endpackage

// File: rtl/pim_ctrl.sv
module pim_ctrl
  import pim_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       memEn,
  input  logic       memWr,
  input  logic       modeBit,
  input  logic [3:0] opField,
  output strobe_t    strb,
  output logic       errFlag
);
  logic errQ;

  always_comb begin
    strb.hostWr = memEn && memWr && !modeBit;
    strb.hostRd = memEn && !memWr && !modeBit;
    strb.instGo = memEn && memWr && modeBit;
    strb.op     = opcode_e'(opField);
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else if (memEn && !memWr && modeBit) errQ <= 1'b1;
  end

  assign errFlag = errQ;
endmodule

// File: rtl/pim_datapath.sv
module pim_datapath
  import pim_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int BIT_AW = 6,
  localparam int NPE   = ROWS * COLS,
  localparam int PE_AW = $clog2(NPE),
  localparam int LB    = 1 << BIT_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [PE_AW-1:0]  peSel,
  input  logic [BIT_AW-1:0] bitSel,
  input  logic              wdata,
  output logic              rdata
);
  logic [NPE-1:0] accVec;
  logic [NPE-1:0] memBitVec;
  logic           rdataQ;

  for (genvar p = 0; p < NPE; p++) begin : g_pe
    localparam int R    = p / COLS;
    localparam int C    = p % COLS;
    localparam int NSRC = ((R + 1) % ROWS) * COLS + C;
    localparam int SSRC = ((R + ROWS - 1) % ROWS) * COLS + C;
    localparam int ESRC = R * COLS + (C + COLS - 1) % COLS;
    localparam int WSRC = R * COLS + (C + 1) % COLS;

    logic          accQ, carryQ, maskQ;
    logic [LB-1:0] memQ;
    logic          opBit;

    assign opBit        = memQ[bitSel];
    assign accVec[p]    = accQ;
    assign memBitVec[p] = opBit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accQ   <= 1'b0;
        carryQ <= 1'b0;
        maskQ  <= 1'b1;
        memQ   <= '0;
      end else begin
        if (strb.hostWr && peSel == PE_AW'(p)) memQ[bitSel] <= wdata;
        if (strb.instGo) begin
          case (strb.op)
            OP_MASKLD:  maskQ <= accQ;
            OP_MASKALL: maskQ <= 1'b1;
            default: begin
              if (maskQ) begin
                case (strb.op)
                  OP_LOAD:  accQ <= opBit;
                  OP_STORE: memQ[bitSel] <= accQ;
                  OP_AND:   accQ <= accQ & opBit;
                  OP_OR:    accQ <= accQ | opBit;
                  OP_XOR:   accQ <= accQ ^ opBit;
                  OP_NOT:   accQ <= ~accQ;
                  OP_ADD: begin
                    accQ   <= accQ ^ opBit ^ carryQ;
                    carryQ <= (accQ & opBit) | (carryQ & (accQ ^ opBit));
                  end
                  OP_SHN:   accQ <= accVec[NSRC];
                  OP_SHS:   accQ <= accVec[SSRC];
                  OP_SHE:   accQ <= accVec[ESRC];
                  OP_SHW:   accQ <= accVec[WSRC];
                  OP_CLRC:  carryQ <= 1'b0;
                  default:  ;
                endcase
              end
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdataQ <= 1'b0;
    else       rdataQ <= strb.hostRd & memBitVec[peSel];
  end

  assign rdata = rdataQ;
endmodule

// File: rtl/pim_array.sv
module pim_array
  import pim_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int BIT_AW = 6,
  localparam int NPE   = ROWS * COLS,
  localparam int PE_AW = $clog2(NPE),
  localparam int AW    = PE_AW + BIT_AW
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        memEn,
  input  logic        memWr,
  input  logic [AW:0] memAddr,
  input  logic        memWdata,
  output logic        memRdata,
  output logic        errFlag
);
  strobe_t strb;

  pim_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .memEn   (memEn),
    .memWr   (memWr),
    .modeBit (memAddr[AW]),
    .opField (memAddr[BIT_AW +: 4]),
    .strb    (strb),
    .errFlag (errFlag)
  );

  pim_datapath #(.ROWS(ROWS), .COLS(COLS), .BIT_AW(BIT_AW)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .peSel  (memAddr[AW-1:BIT_AW]),
    .bitSel (memAddr[BIT_AW-1:0]),
    .wdata  (memWdata),
    .rdata  (memRdata)
  );
endmodule

// File: rtl/pim_array_chk.sv
module pim_array_chk (
  input logic clk,
  input logic rstN,
  input logic memEn,
  input logic memWr,
  input logic modeBit,
  input logic memRdata,
  input logic errFlag
);
  // R1
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memEn && !memWr && !modeBit) |=> !memRdata);

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWr && modeBit) |=> errFlag);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && !(memEn && !memWr && modeBit)) |=> !errFlag);

  // R8
  instrd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWr && modeBit) |=> !memRdata);
endmodule

bind pim_array pim_array_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .memEn    (memEn),
  .memWr    (memWr),
  .modeBit  (memAddr[AW]),
  .memRdata (memRdata),
  .errFlag  (errFlag)
);

// File: tb/pim_array_tb.sv
module pim_array_tb_top;
  localparam int ROWS = 4, COLS = 4, BIT_AW = 6;
  localparam int NPE = ROWS * COLS;
  localparam int LB = 1 << BIT_AW;
  localparam int PE_AW = $clog2(NPE);
  localparam int AW = PE_AW + BIT_AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memEn = 1'b0, memWr = 1'b0, memWdata = 1'b0;
  logic [AW:0] memAddr = '0;
  logic memRdata, errFlag;

  always #5 clk = ~clk;

  pim_array #(.ROWS(ROWS), .COLS(COLS), .BIT_AW(BIT_AW)) dut_i (.*);

  bit mMem[NPE][LB];
  bit mAcc[NPE], mCar[NPE], mMsk[NPE];
  bit expRd, expErr;
  int nRun = 0, nFail = 0;
  string curReq = "R9";
  bit done = 0;

  task automatic modelReset();
    for (int p = 0; p < NPE; p++) begin
      for (int b = 0; b < LB; b++) mMem[p][b] = 0;
      mAcc[p] = 0; mCar[p] = 0; mMsk[p] = 1;
    end
    expRd = 0; expErr = 0;
  endtask

  function automatic int idx(int r, int c);
    return ((r + ROWS) % ROWS) * COLS + ((c + COLS) % COLS);
  endfunction

  task automatic modelStep(bit en, bit wr, int a);
    bit mode = a[AW];
    int hi = (a >> BIT_AW) & ((1 << PE_AW) - 1);
    int b = a & (LB - 1);
    bit old[NPE];
    for (int p = 0; p < NPE; p++) old[p] = mAcc[p];
    expRd = 0;
    if (!en) return;
    if (!mode && !wr) expRd = mMem[hi][b];
    else if (!mode && wr) mMem[hi][b] = memWdata;
    else if (mode && !wr) expErr = 1;
    else begin
      for (int p = 0; p < NPE; p++) begin
        int r = p / COLS, c = p % COLS;
        bit m = mMem[p][b];
        int op = hi & 15;
        if (op == 12) mMsk[p] = old[p];
        else if (op == 13) mMsk[p] = 1;
        else if (mMsk[p]) begin
          case (op)
            1: mAcc[p] = m;
            2: mMem[p][b] = old[p];
            3: mAcc[p] = old[p] & m;
            4: mAcc[p] = old[p] | m;
            5: mAcc[p] = old[p] ^ m;
            6: mAcc[p] = !old[p];
            7: begin
              int s = int'(old[p]) + int'(m) + int'(mCar[p]);
              mAcc[p] = s[0]; mCar[p] = s[1];
            end
            8: mAcc[p] = old[idx(r + 1, c)];
            9: mAcc[p] = old[idx(r - 1, c)];
            10: mAcc[p] = old[idx(r, c - 1)];
            11: mAcc[p] = old[idx(r, c + 1)];
            14: mCar[p] = 0;
            default: ;
          endcase
        end
      end
    end
  endtask

  task automatic cyc(bit en, bit wr, int a, bit wd);
    memEn = en; memWr = wr; memAddr = a[AW:0]; memWdata = wd;
    @(posedge clk);
    modelStep(en, wr, a);
    @(negedge clk);
    nRun++;
    if (memRdata !== expRd || errFlag !== expErr) begin
      nFail++;
      $display("FAIL %s: rdata=%0b err=%0b expected rdata=%0b err=%0b", curReq,
               memRdata, errFlag, expRd, expErr);
    end
  endtask

  function automatic int hAddr(int pe, int b); return (pe << BIT_AW) | b; endfunction
  function automatic int iAddr(int op, int b); return (1 << AW) | (op << BIT_AW) | b; endfunction

  task automatic hwr(int pe, int b, bit v); cyc(1, 1, hAddr(pe, b), v); endtask
  task automatic hrd(int pe, int b); cyc(1, 0, hAddr(pe, b), 0); endtask
  task automatic ins(int op, int b); cyc(1, 1, iAddr(op, b), 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0); endtask
  task automatic rdAll(int b); for (int p = 0; p < NPE; p++) hrd(p, b); idle(); endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not finish");
      report();
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R9";
    idle();
    rdAll(0); rdAll(LB - 1);

    curReq = "R1";
    for (int p = 0; p < NPE; p++)
      for (int b = 0; b < 4; b++) hwr(p, b, ((p + b) % 3) == 0);
    for (int p = 0; p < NPE; p++) hwr(p, LB - 1, p[0]);
    for (int b = 0; b < 4; b++) rdAll(b);
    rdAll(LB - 1);

    curReq = "R2";
    for (int p = 0; p < NPE; p++) hwr(p, 5, (p % 3) == 0);
    ins(1, 5); ins(2, 10); rdAll(10);
    ins(0, 10); ins(15, 10); ins(6, 0); ins(2, 12); rdAll(12);

    curReq = "R3";
    for (int p = 0; p < NPE; p++) hwr(p, 6, p[0]);
    ins(1, 5); ins(3, 6); ins(2, 13); rdAll(13);
    ins(1, 5); ins(4, 6); ins(2, 14); rdAll(14);
    ins(1, 5); ins(5, 6); ins(2, 15); rdAll(15);
    ins(6, 0); ins(2, 16); rdAll(16);

    curReq = "R4";
    for (int p = 0; p < NPE; p++) begin
      int bv = (p * 7 + 3) % 16;
      for (int i = 0; i < 4; i++) begin
        hwr(p, 20 + i, p[i]);
        hwr(p, 24 + i, bv[i]);
      end
    end
    ins(14, 0);
    for (int i = 0; i < 4; i++) begin ins(1, 20 + i); ins(7, 24 + i); ins(2, 28 + i); end
    ins(1, 40); ins(7, 40); ins(2, 32);
    for (int i = 0; i < 5; i++) rdAll(28 + i);
    ins(6, 0); ins(7, 40); ins(14, 0); ins(1, 40); ins(7, 40); ins(2, 33); rdAll(33);

    curReq = "R5";
    for (int p = 0; p < NPE; p++) hwr(p, 41, p == 5 || p == 0);
    ins(1, 41); ins(8, 0); ins(2, 42); rdAll(42);
    ins(10, 0); ins(2, 43); rdAll(43);
    ins(9, 0); ins(9, 0); ins(2, 44); rdAll(44);
    ins(11, 0); ins(11, 0); ins(2, 45); rdAll(45);
    ins(1, 22); ins(10, 0); ins(8, 0); ins(2, 46); rdAll(46);

    curReq = "R6";
    for (int p = 0; p < NPE; p++) begin hwr(p, 47, p[1]); hwr(p, 48, 1); end
    ins(1, 47); ins(12, 0); ins(6, 0); ins(12, 0);
    ins(1, 48); ins(2, 49); rdAll(49);
    ins(14, 0); ins(6, 0); ins(13, 0); ins(2, 50); rdAll(50);

    curReq = "R7";
    for (int p = 0; p < NPE; p++) hwr(p, 51, (p % 5) == 0 || p == 3);
    ins(1, 6); ins(12, 0); ins(1, 51);
    ins(10, 0); ins(8, 0); ins(11, 0); ins(9, 0);
    ins(13, 0); ins(2, 52); rdAll(52);
    ins(1, 51); ins(12, 0); ins(1, 20); ins(8, 0); ins(10, 0);
    ins(13, 0); ins(2, 53); rdAll(53);

    curReq = "R8";
    ins(1, 6);
    cyc(1, 0, iAddr(6, 6), 0);
    idle(); idle();
    ins(2, 54); rdAll(54);
    cyc(1, 0, iAddr(2, 55), 0);
    rdAll(55);
    hwr(3, 56, 1); hrd(3, 56); idle();

    done = 1;
    report();
  end
endmodule